// File: doc/BRIEF.md
# Quadrature Counter Channel with Alternating Preload

This block is one channel of a 24-bit up/down event counter driven from a 16-bit host register port. It counts either the decoded phases of an incremental encoder (phase A, phase B and an index mark) at single, double or quadruple resolution, or a plain clock. The plain clock is a chosen edge of phase A, the system clock, or the system clock divided by two. All pins pass through a two-flop synchroniser. Counting runs entirely in the system clock domain.

Two preload registers feed the counter. The host loads the first one on command. An automatic reload can be triggered by index edges and/or by rollover. It takes its value from whichever preload register a rollover-toggle bit selects. Because every wrap flips that bit, the reload alternates between the two registers. When the count enable is taken from the inverse of the captured-rollover flag, the same counter core produces either a one-shot pulse or a PWM wave on the output pin. Short events are held in sticky status bits. A 24-bit snapshot register gives a coherent read of the count across two 16-bit accesses.

Top module: `qcnt_chan`

## Requirements
- R1: After reset the count, both preload registers, the snapshot, all sticky bits, the toggle bit and the mode word are zero. `cnt_out` is low.
- R2: Normal mode (mode bit 0 = 0) counts in the direction set by mode bit 3 (1 = up). Mode bits 2:1 pick the tick: 0 = rising edge of A, 1 = falling edge of A, 2 = every system clock, 3 = every second system clock.
- R3: Quadrature mode (mode bit 0 = 1) takes its direction from the A/B phase. Forward order is AB = 00,10,11,01. Mode bits 2:1 pick the resolution. With 0, it counts up on an A rise with B low and down on an A fall with B low. With 1, it counts on every A edge. With 2 or 3, it counts on every A and B edge.
- R4: In quadrature mode, if A and B change in the same cycle, status bit 3 is set and the count does not change.
- R5: Counting up from 0xFFFFFF gives 0, and counting down from 0 gives 0xFFFFFF. Each such rollover sets status bit 0 and inverts the toggle bit (status bit 4).
- R6: Status bits 0..3 (rollover, index rise, index fall, illegal transition) stay set until 1 is written to the same bit of the control address.
- R7: Mode bits 6:4 choose the count enable. The choices are 0 = software bit (mode bit 8), 1 = CE pin level, 2 = index level, 3 = index window, and 4 = inverse of status bit 0. Mode bit 7 inverts the chosen enable.
- R8: In window mode the enable rises at an index rising edge and falls at an index falling edge. No counting takes place before the first rising edge.
- R9: A write to the high address (2) only stages its low 8 bits. The staged bits and the low-word data go together into the preload register picked by mode bit 15, and only when the low address (1) is written.
- R10: Writing control bit 15 sets the count and the toggle bit to zero. Writing control bit 14 loads the count from preload 0.
- R11: An automatic reload replaces the count with preload 1 if the toggle bit after the event is 1, and with preload 0 if it is 0. It fires on the OR of the triggers enabled by mode bits 9 (index rise), 10 (index fall) and 11 (rollover).
- R12: `cnt_out` follows status bit 0 when mode bit 12 is 0, or the toggle bit when it is 1. Mode bit 13 inverts it.
- R13: With mode bit 14 = 0, a read of the low address captures the count into the snapshot and returns its low half. With mode bit 14 = 1, the snapshot captures only on an index edge or a `tmr_expire` pulse. The high address always returns the snapshot's top 8 bits. Counting continues through every capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe, data valid next cycle |
| addr | input | 2 | Register address: 0 mode, 1 low word, 2 high word, 3 control/status |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered host read data |
| enc_a | input | 1 | Encoder phase A or plain clock input |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Index mark or general-purpose gate |
| ext_ce | input | 1 | External count enable pin |
| tmr_expire | input | 1 | One-cycle timer expiry strobe, synchronous |
| cnt_out | output | 1 | Configurable counter output |

## Verification
Almost every fault in this channel lasts until the host next looks. A bad toggle bit makes the next automatic reload use the wrong preload register. That shows up as a wrong period on `cnt_out` or a wrong snapshot value one read later. A lost sticky bit is seen only at the next status read. A miscounted quadrature step shifts every later count by one and never heals. So the checks read back the count and status right after each short stimulus burst, and the expected values are worked out edge by edge.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

   typedef enum logic [1:0] {
      RA_MODE = 2'd0,
      RA_LO   = 2'd1,
      RA_HI   = 2'd2,
      RA_CTL  = 2'd3
   } reg_addr_e;

   typedef enum logic [2:0] {
      EN_SOFT  = 3'd0,
      EN_PIN   = 3'd1,
      EN_IDX   = 3'd2,
      EN_WIN   = 3'd3,
      EN_NRCAP = 3'd4
   } en_src_e;

   typedef struct packed {
      logic       pl_sel;
      logic       latch_hw;
      logic       out_inv;
      logic       out_tog;
      logic       al_ro;
      logic       al_fall;
      logic       al_rise;
      logic       sw_en;
      logic       en_inv;
      logic [2:0] en_src;
      logic       dir_up;
      logic [1:0] clk_sel;
      logic       quad;
   } mode_t;

   localparam int CTL_RST = 15;
   localparam int CTL_LD  = 14;
   localparam int NCAP    = 4;

endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_st
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       a,
   input  logic       b,
   input  logic       idx,
   input  logic       quad,
   input  logic [1:0] clk_sel,
   input  logic       dir_up,
   output logic       tick,
   output logic       up,
   output logic       err,
   output logic       idx_rise,
   output logic       idx_fall
);
   logic a_d, b_d, idx_d, div;
   logic a_e, b_e;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         a_d <= 1'b0; b_d <= 1'b0; idx_d <= 1'b0; div <= 1'b0;
      end else begin
         a_d <= a; b_d <= b; idx_d <= idx; div <= ~div;
      end

   assign a_e      = a ^ a_d;
   assign b_e      = b ^ b_d;
   assign idx_rise = idx & ~idx_d;
   assign idx_fall = ~idx & idx_d;

   always_comb begin
      tick = 1'b0;
      up   = dir_up;
      err  = 1'b0;
      if (quad) begin
         err = a_e & b_e;
         unique case (clk_sel)
            2'd0: begin
               tick = a_e & ~b & ~err;
               up   = a;
            end
            2'd1: begin
               tick = a_e & ~err;
               up   = a ^ b;
            end
            default: begin
               tick = (a_e | b_e) & ~err;
               up   = a_e ? (a ^ b) : ~(a ^ b);
            end
         endcase
      end else begin
         unique case (clk_sel)
            2'd0:    tick = a & ~a_d;
            2'd1:    tick = ~a & a_d;
            2'd2:    tick = 1'b1;
            default: tick = div;
         endcase
      end
   end
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core #(
   parameter int CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          up,
   input  logic          ld_rst,
   input  logic          ld_sw,
   input  logic          trig_ext,
   input  logic          al_ro,
   input  logic [CW-1:0] pr0,
   input  logic [CW-1:0] pr1,
   output logic [CW-1:0] count,
   output logic          tog,
   output logic          ro
);
   logic tog_n, trig;

   assign ro    = tick_en & (up ? (&count) : ~(|count));
   assign trig  = trig_ext | (al_ro & ro);
   assign tog_n = ld_rst ? 1'b0 : (tog ^ ro);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         count <= '0;
         tog   <= 1'b0;
      end else begin
         tog <= tog_n;
         if (ld_rst)       count <= '0;
         else if (ld_sw)   count <= pr0;
         else if (trig)    count <= tog_n ? pr1 : pr0;
         else if (tick_en) count <= up ? count + 1'b1 : count - 1'b1;
      end
endmodule

// File: rtl/qcnt_chan.sv
module qcnt_chan
   import qcnt_pkg::*;
#(
   parameter int CW          = 24,
   parameter int HW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [1:0]    addr,
   input  logic [HW-1:0] wdata,
   output logic [HW-1:0] rdata,
   input  logic          enc_a,
   input  logic          enc_b,
   input  logic          enc_idx,
   input  logic          ext_ce,
   input  logic          tmr_expire,
   output logic          cnt_out
);
   localparam int SW = CW - HW;
   localparam int ZW = HW - SW;

   if (CW <= HW || CW > 2*HW) begin : g_bad_width
      $error("qcnt_chan: CW must lie in (HW, 2*HW]");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qcnt_chan: at least two synchroniser stages required");
   end
   if (HW < 8) begin : g_bad_hw
      $error("qcnt_chan: HW too narrow for status word");
   end

   mode_t          mode_q;
   logic [SW-1:0]  stage_q;
   logic [CW-1:0]  pr [2];
   logic [CW-1:0]  snap, count;
   logic [NCAP-1:0] caps;
   logic           win, tog, ro;
   logic           a_s, b_s, idx_s, ce_s;
   logic           tick, up, q_err, idx_rise, idx_fall;
   logic           en_raw, en, hw_ev, trig_ext;
   logic           wr_mode, wr_lo, wr_hi, wr_ctl, rd_lo;

   assign wr_mode = wr_en && addr == RA_MODE;
   assign wr_lo   = wr_en && addr == RA_LO;
   assign wr_hi   = wr_en && addr == RA_HI;
   assign wr_ctl  = wr_en && addr == RA_CTL;
   assign rd_lo   = rd_en && addr == RA_LO;

   qcnt_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({enc_a, enc_b, enc_idx, ext_ce}),
      .q({a_s, b_s, idx_s, ce_s})
   );

   qcnt_decode u_dec (
      .clk(clk), .rst_n(rst_n), .a(a_s), .b(b_s), .idx(idx_s),
      .quad(mode_q.quad), .clk_sel(mode_q.clk_sel), .dir_up(mode_q.dir_up),
      .tick(tick), .up(up), .err(q_err),
      .idx_rise(idx_rise), .idx_fall(idx_fall)
   );

   always_comb begin
      unique case (en_src_e'(mode_q.en_src))
         EN_SOFT:  en_raw = mode_q.sw_en;
         EN_PIN:   en_raw = ce_s;
         EN_IDX:   en_raw = idx_s;
         EN_WIN:   en_raw = win;
         EN_NRCAP: en_raw = ~caps[0];
         default:  en_raw = 1'b0;
      endcase
   end
   assign en       = en_raw ^ mode_q.en_inv;
   assign trig_ext = (mode_q.al_rise & idx_rise) | (mode_q.al_fall & idx_fall);
   assign hw_ev    = idx_rise | idx_fall | tmr_expire;

   qcnt_core #(.CW(CW)) u_core (
      .clk(clk), .rst_n(rst_n),
      .tick_en(tick & en), .up(up),
      .ld_rst(wr_ctl & wdata[CTL_RST]), .ld_sw(wr_ctl & wdata[CTL_LD]),
      .trig_ext(trig_ext), .al_ro(mode_q.al_ro),
      .pr0(pr[0]), .pr1(pr[1]),
      .count(count), .tog(tog), .ro(ro)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mode_q  <= '0;
         stage_q <= '0;
         caps    <= '0;
         win     <= 1'b0;
      end else begin
         if (wr_mode) mode_q  <= mode_t'(wdata);
         if (wr_hi)   stage_q <= wdata[SW-1:0];
         caps <= (caps & ~(wr_ctl ? wdata[NCAP-1:0] : '0))
               | {q_err, idx_fall, idx_rise, ro};
         if (idx_rise)      win <= 1'b1;
         else if (idx_fall) win <= 1'b0;
      end

   for (genvar k = 0; k < 2; k++) begin : g_pr
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                        pr[k] <= '0;
         else if (wr_lo && mode_q.pl_sel == k[0]) pr[k] <= {stage_q, wdata};
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) snap <= '0;
      else if (mode_q.latch_hw ? hw_ev : rd_lo) snap <= count;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) rdata <= '0;
      else if (rd_en) begin
         unique case (reg_addr_e'(addr))
            RA_MODE: rdata <= HW'(mode_q);
            RA_LO:   rdata <= mode_q.latch_hw ? snap[HW-1:0] : count[HW-1:0];
            RA_HI:   rdata <= {{ZW{1'b0}}, snap[CW-1:HW]};
            default: rdata <= {{(HW-NCAP-1){1'b0}}, tog, caps};
         endcase
      end

   assign cnt_out = (mode_q.out_tog ? tog : caps[0]) ^ mode_q.out_inv;
endmodule

// File: rtl/qcnt_chan_chk.sv
module qcnt_chan_chk #(
   parameter int CW = 24,
   parameter int HW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [1:0]    addr,
   input logic [HW-1:0] wdata,
   input logic [CW-1:0] count,
   input logic [CW-1:0] pr0,
   input logic [CW-1:0] snap,
   input logic          tog,
   input logic          rcap,
   input logic          ro,
   input logic          q_err,
   input logic          idx_rise,
   input logic          idx_fall,
   input logic          latch_hw,
   input logic          hw_ev
);
   logic wr_ctl;
   assign wr_ctl = wr_en && addr == 2'd3;

   p_reset_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl && wdata[15] |=> count == '0 && !tog);

   p_load_pr0_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl && wdata[14] && !wdata[15] |=> count == $past(pr0));

   p_rcap_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rcap && !(wr_ctl && wdata[0]) |=> rcap);

   p_toggle_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ro && !(wr_ctl && wdata[15]) |=> tog != $past(tog));

   p_rollover_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ro |=> rcap);

   p_illegal_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      q_err && !wr_en && !idx_rise && !idx_fall |=> $stable(count));

   p_snap_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      latch_hw && !hw_ev |=> $stable(snap));
endmodule

bind qcnt_chan qcnt_chan_chk #(.CW(CW), .HW(HW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .count(count), .pr0(pr[0]), .snap(snap), .tog(tog), .rcap(caps[0]),
   .ro(ro), .q_err(q_err), .idx_rise(idx_rise), .idx_fall(idx_fall),
   .latch_hw(mode_q.latch_hw), .hw_ev(hw_ev)
);

// File: tb/sim_qcnt_chan.sv
module sim_qcnt_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, ext_ce = 1'b0;
   logic        tmr_expire = 1'b0;
   logic        cnt_out;

   int checks = 0, failures = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic        was_rd = 1'b0;
   logic [15:0] cur_mode = 16'd0;

   always #10 clk = ~clk;

   qcnt_chan u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .enc_a(enc_a), .enc_b(enc_b),
      .enc_idx(enc_idx), .ext_ce(ext_ce), .tmr_expire(tmr_expire),
      .cnt_out(cnt_out)
   );

   function automatic logic [15:0] mk(input logic q, input logic [1:0] cs,
      input logic upb, input logic [2:0] es, input logic einv, input logic swen,
      input logic ar, input logic af, input logic aro, input logic otog,
      input logic oinv, input logic lhw);
      return {1'b0, lhw, oinv, otog, aro, af, ar, swen, einv, es, upb, cs, q};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data in issue order
   always @(posedge clk) was_rd <= rd_en;
   always @(negedge clk)
      if (was_rd) begin
         if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
         else chk(tag_q.pop_front(), {16'd0, rdata}, {16'd0, exp_q.pop_front()});
      end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
      exp_q.push_back(e); tag_q.push_back(tag);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic setmode(input logic [15:0] m);
      cur_mode = m;
      wr(2'd0, m);
   endtask

   task automatic load_pr(input logic sel, input logic [23:0] v);
      setmode({sel, cur_mode[14:0]});
      wr(2'd2, {8'd0, v[23:16]});
      wr(2'd1, v[15:0]);
   endtask

   task automatic runsw(input int n);
      setmode(cur_mode | 16'h0100);
      repeat (n - 1) @(negedge clk);
      setmode(cur_mode & ~16'h0100);
   endtask

   task automatic ab(input logic a, input logic b);
      enc_a = a; enc_b = b;
      repeat (4) @(negedge clk);
   endtask

   task automatic idx_pulse();
      enc_idx = 1'b1; repeat (4) @(negedge clk);
      enc_idx = 1'b0; repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cnt_out", {31'd0, cnt_out}, 32'd0);
      rd(2'd3, 16'h0000, "R1 status");
      rd(2'd0, 16'h0000, "R1 mode");
      rd(2'd1, 16'h0000, "R1 count lo");
      rd(2'd2, 16'h0000, "R1 count hi");

      // R9 staging, R10 load command
      setmode(16'h0000);
      wr(2'd2, 16'h0012); wr(2'd1, 16'h3456); wr(2'd3, 16'h4000);
      rd(2'd1, 16'h3456, "R10 load pr0 lo");
      rd(2'd2, 16'h0012, "R9 pr0 hi");
      wr(2'd2, 16'h0077); wr(2'd3, 16'h4000);
      rd(2'd1, 16'h3456, "R9 staged hi not applied lo");
      rd(2'd2, 16'h0012, "R9 staged hi not applied hi");
      wr(2'd3, 16'h8000);
      rd(2'd1, 16'h0000, "R10 reset count");

      // R2 normal clock sources
      setmode(mk(0, 2'd2, 1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0));
      runsw(20);
      rd(2'd1, 16'd20, "R2 internal up");
      setmode(mk(0, 2'd3, 1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h8000);
      runsw(20);
      rd(2'd1, 16'd10, "R2 internal div2");
      setmode(mk(0, 2'd2, 0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0));
      runsw(3);
      rd(2'd1, 16'd7, "R2 internal down");
      setmode(mk(0, 2'd0, 1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h8000);
      for (int i = 0; i < 3; i++) begin ab(1, 0); ab(0, 0); end
      rd(2'd1, 16'd3, "R2 A rising");
      setmode(mk(0, 2'd1, 1, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0));
      for (int i = 0; i < 2; i++) begin ab(1, 0); ab(0, 0); end
      rd(2'd1, 16'd5, "R2 A falling");

      // R5 rollover down, R6 clear, R12 output
      setmode(mk(0, 2'd2, 0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h000F);
      load_pr(0, 24'd2); wr(2'd3, 16'h4000);
      runsw(5);
      rd(2'd1, 16'hFFFD, "R5 underflow lo");
      rd(2'd2, 16'h00FF, "R5 underflow hi");
      rd(2'd3, 16'h0011, "R5 rcap and toggle");
      chk("R12 out follows rcap", {31'd0, cnt_out}, 32'd1);
      wr(2'd3, 16'h0001);
      rd(2'd3, 16'h0010, "R6 write one clears rcap");
      chk("R12 out after clear", {31'd0, cnt_out}, 32'd0);
      setmode(mk(0, 2'd2, 1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0));
      load_pr(0, 24'hFFFFFE); wr(2'd3, 16'h4000);
      runsw(3);
      rd(2'd1, 16'h0001, "R5 overflow wrap");
      rd(2'd3, 16'h0001, "R5 toggle back");

      // R11 alternating autoload
      setmode(mk(0, 2'd2, 0, 3'd0, 0, 0, 0, 0, 1, 1, 0, 0));
      wr(2'd3, 16'h800F);
      load_pr(0, 24'd3); load_pr(1, 24'd1);
      wr(2'd3, 16'h4000);
      runsw(5);
      rd(2'd1, 16'd0, "R11 reload from pr1");
      rd(2'd3, 16'h0011, "R11 toggle set");
      chk("R12 out follows toggle", {31'd0, cnt_out}, 32'd1);
      runsw(1);
      rd(2'd1, 16'd3, "R11 reload from pr0");
      chk("R12 toggle low", {31'd0, cnt_out}, 32'd0);
      setmode(cur_mode | 16'h2000);
      chk("R12 inverted", {31'd0, cnt_out}, 32'd1);

      // R7 one-shot via not-rcap enable
      setmode(mk(0, 2'd2, 0, 3'd4, 0, 0, 0, 0, 0, 0, 1, 0));
      load_pr(0, 24'd3); wr(2'd3, 16'h4000);
      rd(2'd1, 16'd3, "R7 held while rcap set");
      wr(2'd3, 16'h0001);
      chk("R7 pulse active", {31'd0, cnt_out}, 32'd1);
      repeat (10) @(negedge clk);
      rd(2'd1, 16'hFFFF, "R7 one-shot stop lo");
      rd(2'd2, 16'h00FF, "R7 one-shot stop hi");
      chk("R7 pulse ended", {31'd0, cnt_out}, 32'd0);

      // R7 CE pin and inversion
      setmode(mk(0, 2'd2, 1, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h8000);
      ext_ce = 1'b1; repeat (7) @(negedge clk);
      ext_ce = 1'b0; repeat (6) @(negedge clk);
      rd(2'd1, 16'd7, "R7 CE pin window");
      ext_ce = 1'b1; repeat (5) @(negedge clk);
      setmode(mk(0, 2'd2, 1, 3'd1, 1, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h8000);
      repeat (10) @(negedge clk);
      rd(2'd1, 16'd0, "R7 inverted CE blocks");
      setmode(16'h0000);
      ext_ce = 1'b0;

      // R8 index window
      setmode(mk(0, 2'd2, 1, 3'd3, 0, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h8000);
      repeat (5) @(negedge clk);
      rd(2'd1, 16'd0, "R8 idle before index");
      enc_idx = 1'b1; repeat (7) @(negedge clk);
      enc_idx = 1'b0; repeat (6) @(negedge clk);
      rd(2'd1, 16'd7, "R8 window count");

      // R3 quadrature
      setmode(mk(1, 2'd2, 0, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h800F);
      for (int i = 0; i < 2; i++) begin ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0); end
      rd(2'd1, 16'd8, "R3 x4 forward");
      ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0);
      rd(2'd1, 16'd4, "R3 x4 reverse");
      setmode(mk(1, 2'd1, 0, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0));
      ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
      rd(2'd1, 16'd6, "R3 x2 forward");
      setmode(mk(1, 2'd0, 0, 3'd0, 0, 1, 0, 0, 0, 0, 0, 0));
      ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
      rd(2'd1, 16'd7, "R3 x1 forward");
      ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0);
      rd(2'd1, 16'd6, "R3 x1 reverse");

      // R4 illegal transition
      wr(2'd3, 16'h000F);
      ab(1, 1);
      rd(2'd1, 16'd6, "R4 count unchanged");
      rd(2'd3, 16'h0008, "R4 error captured");
      ab(0, 0);

      // R11 autoload on index rise, R6 index captures
      setmode(mk(0, 2'd2, 1, 3'd0, 0, 0, 1, 0, 0, 0, 0, 0));
      wr(2'd3, 16'h800F);
      load_pr(0, 24'h000055);
      idx_pulse();
      rd(2'd1, 16'h0055, "R11 index autoload pr0");
      rd(2'd3, 16'h0006, "R6 index rise and fall captured");

      // R13 hardware latch
      setmode(mk(0, 2'd2, 1, 3'd0, 0, 0, 0, 0, 0, 0, 0, 1));
      load_pr(0, 24'h000010); wr(2'd3, 16'h4000);
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      rd(2'd1, 16'h0010, "R13 timer latch");
      load_pr(0, 24'h000020); wr(2'd3, 16'h4000);
      rd(2'd1, 16'h0010, "R13 read does not latch");
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      rd(2'd1, 16'h0020, "R13 second timer latch");
      load_pr(0, 24'h000030); wr(2'd3, 16'h4000);
      idx_pulse();
      rd(2'd1, 16'h0030, "R13 index latch");

      repeat (3) @(negedge clk);
      chk("scoreboard drained", exp_q.size(), 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule